// File: doc/BRIEF.md
# DMA Descriptor Validation Checker

This block inspects one DMA descriptor of sixteen 32-bit words that an upstream fetch unit has already read from memory. The words arrive together as one flat vector, with a one-cycle valid strobe and a channel index. The block captures them and adds up words 0 to 14 at one word per clock. It then issues exactly one verdict, with a one-cycle done pulse. The verdict is one of four codes: accept, bad preamble, checksum mismatch, or replay of an already-processed descriptor.

In the same done cycle the block reports several results. It gives the per-channel error bit for a rejection. For an accepted descriptor it says whether the chain stops after it. It also gives a channel status word decoded from the control word. When the descriptor asks for it, the block raises a completion interrupt request and presents a write-back copy of the descriptor with its done flag set.

Word 0 is the control word, word 5 is the timestamp-high word, and word 15 holds the checksum. Word i occupies bits [32*i+31 : 32*i] of the input vector.

Top module: `dscr_guard`

## Requirements
- R1: A valid strobe seen while idle captures the words and channel, and busy is high from the next cycle. A valid strobe seen while busy is ignored and does not change the verdict of the descriptor in progress.
- R2: The done pulse lasts one cycle and comes 16 clock edges after the capturing edge. Busy falls on that same edge.
- R3: If control bits [7:0] differ from 0xA5, the verdict is code 1 (bad preamble) and the error vector has only bit 7+channel set.
- R4: If control bit 20 is set and the 32-bit wrapping sum of words 0..14 differs from word 15, the verdict is code 2 and only error bit 13+channel is set. If control bit 20 is clear, word 15 is not examined.
- R5: If timestamp-high bit 31 is set and control bit 10 is clear, the verdict is code 3 (replay) and only error bit 25+channel is set. If control bit 10 is set, the done flag is disregarded.
- R6: The checks are ranked preamble first, then checksum, then replay, and only the first failure is reported. An accepted descriptor gets code 0 with an all-zero error vector. The error vector is zero outside the done cycle.
- R7: In the done cycle, chain-end is high only when the verdict is accept and control bit 19 or bit 21 is set.
- R8: Status word, built for every verdict, with all unlisted bits zero:
  - bits [20:13] = control[7:0]
  - bit 12 = control 8
  - bit 11 = control 9
  - bit 10 = timestamp-high 31
  - bit 9 = control 10
  - bit 8 = control 21
  - bit 7 = control 19
  - bit 6 = control 20
  - bit 5 = control 18
  - bit 4 = control 11
- R9: When the verdict is accept and control bit 9 is set, the write-back valid pulses in the done cycle. The write-back words equal the input words, with bit 31 of word 5 forced to 1.
- R10: When the verdict is accept and control bit 8 is set, the interrupt vector carries only bit `channel` in the done cycle. Otherwise it is zero.
- R11: After reset, busy, done, result, error vector, chain-end, status, interrupt vector and write-back valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor present strobe |
| in_words | input | 512 | Sixteen descriptor words, word i at [32i+31:32i] |
| in_chan | input | 3 | Channel index 0..5 |
| busy | output | 1 | A descriptor is being checked |
| out_done | output | 1 | One-cycle verdict pulse |
| out_result | output | 2 | 0 accept, 1 bad preamble, 2 checksum mismatch, 3 replay |
| out_err_bits | output | 32 | Per-channel error bit, done cycle only |
| out_chain_end | output | 1 | Chain stops after this descriptor |
| out_status | output | 32 | Decoded channel status word |
| out_irq | output | 6 | Completion interrupt request per channel |
| out_wb_valid | output | 1 | Write-back copy is to be stored |
| out_wb_words | output | 512 | Write-back copy with done flag set |

## Verification
Every result of this block lands in a single cycle: the done cycle, 16 edges after the capturing edge. The bench's reference model counts those edges itself from the valid strobe it drove. On every clock, the model compares busy and done. Only when its own count reaches 16 does it compare the verdict, error vector, chain-end, status, interrupt vector and write-back words. A second strobe is driven mid-check, and the model must still hold the first descriptor's verdict.

// File: rtl/dg_pkg.sv
package dg_pkg;
    typedef enum logic [1:0] {
        DG_OK      = 2'd0,
        DG_BAD_PRE = 2'd1,
        DG_BAD_SUM = 2'd2,
        DG_REPLAY  = 2'd3
    } dg_res_e;

    // word positions inside the descriptor
    localparam int unsigned CTRL_IDX = 0;
    localparam int unsigned TSHI_IDX = 5;

    localparam logic [7:0] PREAMBLE_TAG = 8'hA5;

    // control word bit positions
    localparam int unsigned CB_IRQ    = 8;
    localparam int unsigned CB_UPD    = 9;
    localparam int unsigned CB_IGN    = 10;
    localparam int unsigned CB_BURST  = 11;
    localparam int unsigned CB_MODE   = 18;
    localparam int unsigned CB_LAST   = 19;
    localparam int unsigned CB_CSUM   = 20;
    localparam int unsigned CB_LFRAME = 21;
    localparam int unsigned TS_DONE   = 31;

    // error vector base offsets (channel is added)
    localparam int unsigned EOFF_PRE = 7;
    localparam int unsigned EOFF_SUM = 13;
    localparam int unsigned EOFF_REP = 25;
endpackage

// File: rtl/dg_sum_acc.sv
module dg_sum_acc #(
    parameter int unsigned W      = 32,
    parameter int unsigned NWORDS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NWORDS*W-1:0] words,
    output logic [W-1:0]        sum,
    output logic                fin
);
    localparam int unsigned IW = $clog2(NWORDS);
    localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);

    typedef struct packed {
        logic          run;
        logic [IW-1:0] cnt;
        logic [W-1:0]  acc;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
            st_d.acc = '0;
        end else if (st_q.run && st_q.cnt != LAST) begin
            st_d.acc = st_q.acc + words[st_q.cnt*W +: W];
            st_d.cnt = st_q.cnt + IW'(1);
        end else if (st_q.run) begin
            st_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum = st_q.acc;
    assign fin = st_q.run && (st_q.cnt == LAST);
endmodule

// File: rtl/dg_verdict.sv
module dg_verdict
    import dg_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = 3
) (
    input  logic [W-1:0]  ctrl,
    input  logic [W-1:0]  tshi,
    input  logic [W-1:0]  csum_word,
    input  logic [W-1:0]  sum,
    input  logic [CW-1:0] chan,
    output dg_res_e       res,
    output logic [W-1:0]  err_bits,
    output logic          chain_end
);
    localparam logic [W-1:0] ONE_W = 1;

    logic unused_bits;
    assign unused_bits = ^{ctrl[W-1:CB_LFRAME+1], ctrl[CB_LAST-1:CB_IGN+1],
                           ctrl[CB_IGN-1:8], tshi[TS_DONE-1:0]};

    always_comb begin
        res       = DG_OK;
        err_bits  = '0;
        chain_end = 1'b0;
        if (ctrl[7:0] != PREAMBLE_TAG) begin
            res      = DG_BAD_PRE;
            err_bits = ONE_W << (EOFF_PRE + chan);
        end else if (ctrl[CB_CSUM] && sum != csum_word) begin
            res      = DG_BAD_SUM;
            err_bits = ONE_W << (EOFF_SUM + chan);
        end else if (tshi[TS_DONE] && !ctrl[CB_IGN]) begin
            res      = DG_REPLAY;
            err_bits = ONE_W << (EOFF_REP + chan);
        end else begin
            chain_end = ctrl[CB_LAST] | ctrl[CB_LFRAME];
        end
    end
endmodule

// File: rtl/dg_status_map.sv
module dg_status_map
    import dg_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] ctrl,
    input  logic [W-1:0] tshi,
    output logic [W-1:0] status
);
    logic unused_sbits;
    assign unused_sbits = ^{ctrl[W-1:CB_LFRAME+1], ctrl[CB_MODE-1:CB_BURST+1],
                            tshi[TS_DONE-1:0]};

    always_comb begin
        status        = '0;
        status[20:13] = ctrl[7:0];
        status[12]    = ctrl[CB_IRQ];
        status[11]    = ctrl[CB_UPD];
        status[10]    = tshi[TS_DONE];
        status[9]     = ctrl[CB_IGN];
        status[8]     = ctrl[CB_LFRAME];
        status[7]     = ctrl[CB_LAST];
        status[6]     = ctrl[CB_CSUM];
        status[5]     = ctrl[CB_MODE];
        status[4]     = ctrl[CB_BURST];
    end
endmodule

// File: rtl/dscr_guard.sv
module dscr_guard
    import dg_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned NWORDS = 16,
    parameter int unsigned NCH    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [NWORDS*W-1:0] in_words,
    input  logic [2:0]          in_chan,
    output logic                busy,
    output logic                out_done,
    output logic [1:0]          out_result,
    output logic [W-1:0]        out_err_bits,
    output logic                out_chain_end,
    output logic [W-1:0]        out_status,
    output logic [NCH-1:0]      out_irq,
    output logic                out_wb_valid,
    output logic [NWORDS*W-1:0] out_wb_words
);
    localparam int unsigned CW = 3;
    localparam int unsigned CSUM_IDX = NWORDS - 1;
    localparam logic [NCH-1:0] ONE_CH = 1;

    typedef struct packed {
        logic                busy;
        logic                done;
        logic [CW-1:0]       chan;
        logic [NWORDS*W-1:0] words;
        dg_res_e             res;
        logic [W-1:0]        err;
        logic                chain;
        logic [W-1:0]        status;
        logic [NCH-1:0]      irq;
        logic                wb;
    } top_t;

    top_t st_d, st_q;

    logic          start;
    logic          fin;
    logic [W-1:0]  sum;
    logic [W-1:0]  ctrl_w, tshi_w, csum_w;
    dg_res_e       v_res;
    logic [W-1:0]  v_err;
    logic          v_chain;
    logic [W-1:0]  v_status;

    assign start  = in_valid && !st_q.busy;
    assign ctrl_w = st_q.words[CTRL_IDX*W +: W];
    assign tshi_w = st_q.words[TSHI_IDX*W +: W];
    assign csum_w = st_q.words[CSUM_IDX*W +: W];

    dg_sum_acc #(.W(W), .NWORDS(NWORDS)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .words (st_q.words),
        .sum   (sum),
        .fin   (fin)
    );

    dg_verdict #(.W(W), .CW(CW)) u_verdict (
        .ctrl      (ctrl_w),
        .tshi      (tshi_w),
        .csum_word (csum_w),
        .sum       (sum),
        .chan      (st_q.chan),
        .res       (v_res),
        .err_bits  (v_err),
        .chain_end (v_chain)
    );

    dg_status_map #(.W(W)) u_status (
        .ctrl   (ctrl_w),
        .tshi   (tshi_w),
        .status (v_status)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = '0;
        st_d.irq  = '0;
        st_d.wb   = 1'b0;
        if (start) begin
            st_d.busy  = 1'b1;
            st_d.chan  = in_chan;
            st_d.words = in_words;
        end else if (st_q.busy && fin) begin
            st_d.busy   = 1'b0;
            st_d.done   = 1'b1;
            st_d.res    = v_res;
            st_d.err    = v_err;
            st_d.chain  = v_chain;
            st_d.status = v_status;
            if (v_res == DG_OK && ctrl_w[CB_IRQ]) st_d.irq = ONE_CH << st_q.chan;
            st_d.wb     = (v_res == DG_OK) && ctrl_w[CB_UPD];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        out_wb_words = st_q.words;
        out_wb_words[TSHI_IDX*W + TS_DONE] = 1'b1;
    end

    assign busy          = st_q.busy;
    assign out_done      = st_q.done;
    assign out_result    = st_q.res;
    assign out_err_bits  = st_q.err;
    assign out_chain_end = st_q.chain;
    assign out_status    = st_q.status;
    assign out_irq       = st_q.irq;
    assign out_wb_valid  = st_q.wb;
endmodule

// File: rtl/dg_guard_chk.sv
module dg_guard_chk #(
    parameter int unsigned W      = 32,
    parameter int unsigned NWORDS = 16,
    parameter int unsigned NCH    = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           busy,
    input logic           out_done,
    input logic [1:0]     out_result,
    input logic [W-1:0]   out_err_bits,
    input logic           out_chain_end,
    input logic [NCH-1:0] out_irq,
    input logic           out_wb_valid
);
    localparam int unsigned LW = $clog2(NWORDS) + 2;
    logic [LW-1:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    lat_q <= '0;
        else if (busy) lat_q <= lat_q + LW'(1);
        else           lat_q <= '0;
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !busy |=> busy); // R1
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (lat_q == LW'(NWORDS)) && !busy); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done); // R2
    AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_err_bits)); // R6
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_done |-> out_err_bits == '0); // R6
    AST_ERR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_done && out_result != 2'd0 |-> $countones(out_err_bits) == 1); // R6
    AST_CHAIN_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_done && out_chain_end |-> out_result == 2'd0); // R7
    AST_WB_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_wb_valid |-> out_done && out_result == 2'd0); // R9
    AST_IRQ_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_irq != '0 |-> out_done && out_result == 2'd0 && $onehot(out_irq)); // R10
endmodule

bind dscr_guard dg_guard_chk #(.W(W), .NWORDS(NWORDS), .NCH(NCH)) u_guard_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .busy          (busy),
    .out_done      (out_done),
    .out_result    (out_result),
    .out_err_bits  (out_err_bits),
    .out_chain_end (out_chain_end),
    .out_irq       (out_irq),
    .out_wb_valid  (out_wb_valid)
);

// File: tb/dscr_guard_bench.sv
`timescale 1ns/1ps
module dscr_guard_bench;
    localparam int W = 32;
    localparam int NW = 16;
    localparam int NCH = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [NW*W-1:0] in_words = '0;
    logic [2:0]      in_chan = '0;
    logic            busy, out_done, out_chain_end, out_wb_valid;
    logic [1:0]      out_result;
    logic [W-1:0]    out_err_bits, out_status;
    logic [NCH-1:0]  out_irq;
    logic [NW*W-1:0] out_wb_words;

    always #2 clk = ~clk;

    dscr_guard u_dscr_guard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in_words),
        .in_chan(in_chan), .busy(busy), .out_done(out_done),
        .out_result(out_result), .out_err_bits(out_err_bits),
        .out_chain_end(out_chain_end), .out_status(out_status),
        .out_irq(out_irq), .out_wb_valid(out_wb_valid),
        .out_wb_words(out_wb_words)
    );

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model state
    bit              m_busy = 0;
    bit              m_done = 0;
    int              m_t = 0;
    logic [1:0]      e_res;
    logic [W-1:0]    e_err, e_status;
    bit              e_chain, e_wb;
    logic [NCH-1:0]  e_irq;
    logic [NW*W-1:0] e_words;

    function automatic void predict(input logic [NW*W-1:0] wv, input int ch);
        logic [W-1:0] s, c, t;
        s = 0;
        for (int i = 0; i < 15; i++) s += wv[i*W +: W];
        c = wv[0 +: W];
        t = wv[5*W +: W];
        if (c[7:0] != 8'hA5)                e_res = 2'd1;
        else if (c[20] && s != wv[15*W +: W]) e_res = 2'd2;
        else if (t[31] && !c[10])           e_res = 2'd3;
        else                                e_res = 2'd0;
        case (e_res)
            2'd1: e_err = 32'd1 << (7 + ch);
            2'd2: e_err = 32'd1 << (13 + ch);
            2'd3: e_err = 32'd1 << (25 + ch);
            default: e_err = 32'd0;
        endcase
        e_chain = (e_res == 2'd0) && (c[19] || c[21]);
        e_status = {11'd0, c[7:0], c[8], c[9], t[31], c[10], c[21], c[19], c[20], c[18], c[11], 4'd0};
        e_irq = (e_res == 2'd0 && c[8]) ? (NCH'(1) << ch) : '0;
        e_wb = (e_res == 2'd0) && c[9];
        e_words = wv;
        e_words[5*W + 31] = 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_t = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_t++;
                if (m_t == 16) begin m_busy = 0; m_done = 1; end
            end else if (in_valid) begin
                m_busy = 1; m_t = 0;
                predict(in_words, int'(in_chan));
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 busy", 32'(busy), 32'(m_busy));
            chk("R2 done", 32'(out_done), 32'(m_done));
            if (m_done) begin
                chk("R3/R4/R5 result", 32'(out_result), 32'(e_res));
                chk("R6 error bits", out_err_bits, e_err);
                chk("R7 chain end", 32'(out_chain_end), 32'(e_chain));
                chk("R8 status", out_status, e_status);
                chk("R10 irq", 32'(out_irq), 32'(e_irq));
                chk("R9 wb valid", 32'(out_wb_valid), 32'(e_wb));
                if (e_wb)
                    for (int i = 0; i < NW; i++)
                        chk("R9 wb word", out_wb_words[i*W +: W], e_words[i*W +: W]);
            end
        end
    end

    // build a descriptor; sum_ok selects a correct checksum word
    function automatic logic [NW*W-1:0] mk(input logic [W-1:0] ctrl, input logic [W-1:0] tshi,
                                           input bit sum_ok, input int seed);
        logic [NW*W-1:0] v;
        logic [W-1:0] s;
        s = 0;
        for (int i = 0; i < NW; i++) v[i*W +: W] = 32'h9E3779B9 * (i + 1) + 32'(seed) * 32'h01000193;
        v[0 +: W] = ctrl;
        v[5*W +: W] = tshi;
        for (int i = 0; i < 15; i++) s += v[i*W +: W];
        v[15*W +: W] = sum_ok ? s : s + 32'd1;
        return v;
    endfunction

    task automatic send(input logic [NW*W-1:0] v, input int ch);
        @(negedge clk);
        while (busy) @(negedge clk);
        in_words = v; in_chan = 3'(ch); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (18) @(negedge clk);
    endtask

    localparam logic [W-1:0] PRE = 32'h0000_00A5;

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", 32'(busy), 0);
        chk("R11 done", 32'(out_done), 0);
        chk("R11 result", 32'(out_result), 0);
        chk("R11 err", out_err_bits, 0);
        chk("R11 chain", 32'(out_chain_end), 0);
        chk("R11 status", out_status, 0);
        chk("R11 irq", 32'(out_irq), 0);
        chk("R11 wb", 32'(out_wb_valid), 0);
        rst_n = 1'b1;

        send(mk(PRE, 32'h0, 0, 1), 0);                                  // R4 check disabled: accept
        send(mk(32'h0010_005A, 32'h8000_0000, 0, 2), 2);                // R3 + R6 priority
        send(mk(PRE | (1 << 20) | (1 << 19), 32'h0, 1, 3), 1);          // R4 good sum, R7 last
        send(mk(PRE | (1 << 20), 32'h8000_0000, 0, 4), 3);              // R4 bad sum over replay, R6
        send(mk(PRE, 32'h8000_0000, 1, 5), 5);                          // R5 replay
        send(mk(PRE | (1 << 10), 32'h8000_0000, 1, 6), 4);              // R5 ignore done
        send(mk(PRE | (1 << 21) | (1 << 8) | (1 << 9), 32'h0, 0, 7), 2); // R7 frame end, R9, R10
        send(mk(PRE | (1 << 8) | (1 << 9) | (1 << 10) | (1 << 11) | (1 << 18) | (1 << 19)
                | (1 << 20) | (1 << 21), 32'h8000_1234, 1, 8), 5);     // R8 all status bits
        send(mk(PRE | (1 << 8) | (1 << 20), 32'h0, 0, 9), 0);           // R4 bad sum suppresses R10

        // R1: second strobe while busy is ignored
        @(negedge clk);
        while (busy) @(negedge clk);
        in_words = mk(PRE | (1 << 8), 32'h0, 1, 10); in_chan = 3'd3; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        in_words = mk(32'h0000_0011, 32'h0, 1, 11); in_chan = 3'd1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (16) @(negedge clk);
        chk("R1 idle after ignored strobe", 32'(busy), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errs++; checks++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule